// File: doc/BRIEF.md
# Result-Latency Interlock Scoreboard

This block is the hazard interlock at the decode stage of a single-issue, in-order pipeline. The pipeline's execution units differ in two ways: how often each can accept a new operation, and how many extra cycles pass before its result can be read. For every architectural register the block keeps a countdown of the cycles left until an in-flight result becomes usable. For every unit it keeps a countdown of the cycles left until the unit can accept another operation.

Decode presents one instruction per cycle: two source register indices, a destination index, a unit class and a valid bit. The block raises `stall` when a source names a register whose countdown is still running, or when the selected unit is still inside its issue interval. Decode then holds the instruction and presents it again. An instruction that reads nothing pending goes through at once, so a long-latency result costs nothing when the code places independent work after it. Register 0 is the hard-wired zero register and a write of 0 means "no destination".

Top module: `sb_scoreboard`

## Requirements
- R1: After reset every register countdown and every unit countdown is zero, so the first valid instruction after reset is not stalled, whatever it reads.
- R2: `stall` is 0 in every cycle where `id_valid` is 0, even if the sources on the bus name pending registers.
- R3: A producer with result latency L > 0 that issues in cycle t makes an instruction that reads its destination (through either source) and is presented from cycle t+1 stall for exactly L cycles. It issues in cycle t+1+L. The unit code is `id_unit` = 0 ALU (latency 0), 1 MUL (latency 2), 2 MULX (latency 2), 3 DIV (latency 36).
- R4: An instruction whose sources are not pending and whose unit is free issues without stall. In particular, a MUL followed by two independent ALU operations and then an ALU operation that reads the MUL result issues all four back to back.
- R5: Register 0 is never pending. A write to register 0 starts no countdown, and a read of register 0 never stalls.
- R6: A unit with issue interval C accepts a new operation no earlier than C cycles after its previous one. Back-to-back operations on that unit stall C-1 cycles. The defaults are ALU 1, MUL 1, MULX 2 and DIV 35.
- R7: An issued instruction's destination countdown is overwritten with its own unit's latency. A later ALU write to a register that a MUL was still producing clears the pending state, and a reader that follows does not stall.
- R8: The result of an ALU operation (latency 0) can be read by the very next instruction without stall.
- R9: A busy unit delays only instructions of its own class. A MUL or ALU operation presented while DIV is inside its issue interval issues at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | An instruction is presented this cycle |
| id_src_a | input | $clog2(NREGS) | First source register index |
| id_src_b | input | $clog2(NREGS) | Second source register index |
| id_dst | input | $clog2(NREGS) | Destination register index, 0 for none |
| id_unit | input | 2 | Unit class: 0 ALU, 1 MUL, 2 MULX, 3 DIV |
| stall | output | 1 | Hold the presented instruction this cycle |

## Verification
The properties assume that decode behaves like a real pipeline. A stalled instruction is held rather than dropped, no instruction arrives while reset is asserted, and `id_unit` always carries one of the four defined codes. The stimulus keeps to this. Every instruction is presented repeatedly until the bench model says it issues. Reset is released before the first instruction. Random unit codes are drawn only from the four classes. Random register indices are confined to a small range, including register 0, so that dependencies, same-destination rewrites and zero-register reads occur often.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;

    typedef enum logic [1:0] {
        UNIT_ALU  = 2'd0,
        UNIT_MUL  = 2'd1,
        UNIT_MULX = 2'd2,
        UNIT_DIV  = 2'd3
    } unit_e;

    localparam int unsigned NUM_UNITS = 4;

    // Select one of four per-unit timing values by unit class.
    function automatic int unsigned pick_unit(input unit_e u,
                                              input int unsigned v_alu,
                                              input int unsigned v_mul,
                                              input int unsigned v_mulx,
                                              input int unsigned v_div);
        case (u)
            UNIT_ALU:  return v_alu;
            UNIT_MUL:  return v_mul;
            UNIT_MULX: return v_mulx;
            default:   return v_div;
        endcase
    endfunction

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sb_pend_table.sv
`timescale 1ns/1ps
module sb_pend_table #(
    parameter  int unsigned NREGS = 32,
    parameter  int unsigned CW    = 6,
    localparam int unsigned RW    = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_en,
    input  logic [RW-1:0] set_idx,
    input  logic [CW-1:0] set_val,
    input  logic [RW-1:0] rd_a,
    input  logic [RW-1:0] rd_b,
    output logic          pend_a,
    output logic          pend_b
);
    logic [NREGS-1:0] pend_vec;

    for (genvar r = 0; r < NREGS; r++) begin : g_reg
        if (r == 0) begin : g_zero
            // the zero register never carries a countdown
            assign pend_vec[r] = 1'b0;
        end else begin : g_cnt
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst)
                    cnt <= '0;
                else if (set_en && set_idx == RW'(r))
                    cnt <= set_val;
                else if (cnt != '0)
                    cnt <= cnt - 1'b1;
            end
            assign pend_vec[r] = (cnt != '0);
        end
    end

    assign pend_a = pend_vec[rd_a];
    assign pend_b = pend_vec[rd_b];
endmodule

// File: rtl/sb_issue_gate.sv
`timescale 1ns/1ps
module sb_issue_gate #(
    parameter  int unsigned CPI = 1,
    localparam int unsigned GW  = (CPI > 1) ? $clog2(CPI) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic busy
);
    logic [GW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (fire)
            cnt <= GW'(CPI - 1);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/sb_scoreboard.sv
`timescale 1ns/1ps
module sb_scoreboard
    import sb_pkg::*;
#(
    parameter  int unsigned NREGS    = 32,
    parameter  int unsigned ALU_CPI  = 1,
    parameter  int unsigned ALU_LAT  = 0,
    parameter  int unsigned MUL_CPI  = 1,
    parameter  int unsigned MUL_LAT  = 2,
    parameter  int unsigned MULX_CPI = 2,
    parameter  int unsigned MULX_LAT = 2,
    parameter  int unsigned DIV_CPI  = 35,
    parameter  int unsigned DIV_LAT  = 36,
    localparam int unsigned RW       = $clog2(NREGS),
    localparam int unsigned LAT_MAX  = max4(ALU_LAT, MUL_LAT, MULX_LAT, DIV_LAT),
    localparam int unsigned CW       = (LAT_MAX > 0) ? $clog2(LAT_MAX + 1) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          id_valid,
    input  logic [RW-1:0] id_src_a,
    input  logic [RW-1:0] id_src_b,
    input  logic [RW-1:0] id_dst,
    input  logic [1:0]    id_unit,
    output logic          stall
);
    unit_e                  cur_unit;
    logic [CW-1:0]          cur_lat;
    logic [NUM_UNITS-1:0]   unit_busy;
    logic                   pend_a, pend_b;
    logic                   fire;
    logic                   lat_nz;
    logic                   cpi_gt1;

    assign cur_unit = unit_e'(id_unit);
    assign cur_lat  = CW'(pick_unit(cur_unit, ALU_LAT, MUL_LAT, MULX_LAT, DIV_LAT));
    assign lat_nz   = (cur_lat != '0);
    assign cpi_gt1  = pick_unit(cur_unit, ALU_CPI, MUL_CPI, MULX_CPI, DIV_CPI) > 1;

    sb_pend_table #(.NREGS(NREGS), .CW(CW)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .set_en  (fire && id_dst != '0),
        .set_idx (id_dst),
        .set_val (cur_lat),
        .rd_a    (id_src_a),
        .rd_b    (id_src_b),
        .pend_a  (pend_a),
        .pend_b  (pend_b)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        sb_issue_gate #(
            .CPI(pick_unit(unit_e'(u), ALU_CPI, MUL_CPI, MULX_CPI, DIV_CPI))
        ) u_gate (
            .clk  (clk),
            .rst  (rst),
            .fire (fire && id_unit == 2'(u)),
            .busy (unit_busy[u])
        );
    end

    assign stall = id_valid && (pend_a || pend_b || unit_busy[id_unit]);
    assign fire  = id_valid && !stall;
endmodule

// File: rtl/sb_checker.sv
`timescale 1ns/1ps
module sb_checker #(
    parameter int unsigned RW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          id_valid,
    input logic [RW-1:0] id_src_a,
    input logic [RW-1:0] id_src_b,
    input logic [RW-1:0] id_dst,
    input logic [1:0]    id_unit,
    input logic          stall,
    input logic          fire,
    input logic [3:0]    unit_busy,
    input logic          lat_nz,
    input logic          cpi_gt1
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !stall);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !id_valid |-> !stall);

    // R3
    dep_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && lat_nz && id_dst != '0) |=>
        (!(id_valid && (id_src_a == $past(id_dst) || id_src_b == $past(id_dst))) || stall));

    // R5
    zero_src_chk: assert property (@(posedge clk) disable iff (rst)
        (id_valid && id_src_a == '0 && id_src_b == '0 && !unit_busy[id_unit]) |-> !stall);

    // R6
    unit_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && cpi_gt1) |=> (!(id_valid && id_unit == $past(id_unit)) || stall));
endmodule

bind sb_scoreboard sb_checker #(.RW(RW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .id_valid  (id_valid),
    .id_src_a  (id_src_a),
    .id_src_b  (id_src_b),
    .id_dst    (id_dst),
    .id_unit   (id_unit),
    .stall     (stall),
    .fire      (fire),
    .unit_busy (unit_busy),
    .lat_nz    (lat_nz),
    .cpi_gt1   (cpi_gt1)
);

// File: tb/tb_sb_scoreboard.sv
`timescale 1ns/1ps
module tb_sb_scoreboard;
    localparam logic [1:0] U_ALU = 2'd0, U_MUL = 2'd1, U_MULX = 2'd2, U_DIV = 2'd3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       id_valid = 1'b0;
    logic [4:0] id_src_a = '0, id_src_b = '0, id_dst = '0;
    logic [1:0] id_unit = '0;
    logic       stall;

    int checks = 0;
    int fails  = 0;
    int pend [32];
    int busy [4];

    always #2 clk = ~clk;

    sb_scoreboard dut (
        .clk(clk), .rst(rst), .id_valid(id_valid),
        .id_src_a(id_src_a), .id_src_b(id_src_b), .id_dst(id_dst),
        .id_unit(id_unit), .stall(stall)
    );

    function automatic int cpi_of(input logic [1:0] u);
        case (u) 2'd0: return 1; 2'd1: return 1; 2'd2: return 2; default: return 35; endcase
    endfunction

    function automatic int lat_of(input logic [1:0] u);
        case (u) 2'd0: return 0; 2'd1: return 2; 2'd2: return 2; default: return 36; endcase
    endfunction

    function automatic bit model_stall(input bit v, input logic [4:0] a, input logic [4:0] b,
                                       input logic [1:0] u);
        if (!v) return 1'b0;
        return (a != 0 && pend[a] != 0) || (b != 0 && pend[b] != 0) || busy[u] != 0;
    endfunction

    task automatic model_step(input bit issued, input logic [4:0] d, input logic [1:0] u);
        for (int r = 0; r < 32; r++) if (pend[r] > 0) pend[r]--;
        for (int k = 0; k < 4; k++) if (busy[k] > 0) busy[k]--;
        if (issued) begin
            busy[u] = cpi_of(u) - 1;
            if (d != 0) pend[d] = lat_of(u);
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Present one instruction until it issues; exp_stalls < 0 skips the count check.
    task automatic issue(input logic [4:0] a, input logic [4:0] b, input logic [4:0] d,
                         input logic [1:0] u, input int exp_stalls, input string req);
        int n = 0;
        bit e;
        forever begin
            @(negedge clk);
            id_valid = 1'b1; id_src_a = a; id_src_b = b; id_dst = d; id_unit = u;
            #1;
            e = model_stall(1'b1, a, b, u);
            check(stall === e, req, int'(stall), int'(e));
            model_step(!e, d, u);
            if (!e) break;
            n++;
            if (n > 200) break;
        end
        if (exp_stalls >= 0) check(n == exp_stalls, req, n, exp_stalls);
    endtask

    task automatic idle(input int cycles, input logic [4:0] a);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            id_valid = 1'b0; id_src_a = a; id_src_b = a;
            #1;
            check(stall === 1'b0, "R2", int'(stall), 0);
            model_step(1'b0, 5'd0, 2'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int r = 0; r < 32; r++) pend[r] = 0;
        for (int k = 0; k < 4; k++) busy[k] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: first instruction after reset, reading registers never written
        issue(5'd1, 5'd2, 5'd3, U_ALU, 0, "R1");
        // R3: mul then dependent add waits the two latency cycles
        issue(5'd2, 5'd3, 5'd1, U_MUL, 0, "R3");
        issue(5'd1, 5'd0, 5'd1, U_ALU, 2, "R3");
        // R4: mul, two independent ops, then dependent add: no stall anywhere
        issue(5'd2, 5'd3, 5'd1, U_MUL, 0, "R4");
        issue(5'd5, 5'd6, 5'd5, U_ALU, 0, "R4");
        issue(5'd7, 5'd8, 5'd7, U_ALU, 0, "R4");
        issue(5'd1, 5'd0, 5'd1, U_ALU, 0, "R4");
        // R8: ALU result read at once
        issue(5'd2, 5'd3, 5'd4, U_ALU, 0, "R8");
        issue(5'd4, 5'd4, 5'd9, U_ALU, 0, "R8");
        // R5: write to r0 starts nothing, read of r0 never stalls
        issue(5'd2, 5'd3, 5'd0, U_MUL, 0, "R5");
        issue(5'd0, 5'd0, 5'd10, U_ALU, 0, "R5");
        // R7: later ALU write replaces the MUL countdown
        issue(5'd2, 5'd2, 5'd3, U_MUL, 0, "R7");
        issue(5'd0, 5'd0, 5'd3, U_ALU, 0, "R7");
        issue(5'd3, 5'd0, 5'd11, U_ALU, 0, "R7");
        // R6: back-to-back MULX waits one cycle, DIV waits 34
        issue(5'd0, 5'd0, 5'd0, U_MULX, 0, "R6");
        issue(5'd0, 5'd0, 5'd0, U_MULX, 1, "R6");
        issue(5'd0, 5'd0, 5'd0, U_DIV, 0, "R6");
        issue(5'd0, 5'd0, 5'd0, U_DIV, 34, "R6");
        // R9: other units proceed while DIV is busy
        issue(5'd0, 5'd0, 5'd0, U_DIV, 34, "R9");
        issue(5'd1, 5'd2, 5'd12, U_MUL, 0, "R9");
        issue(5'd1, 5'd2, 5'd13, U_ALU, 0, "R9");
        idle(40, 5'd0);
        // R3: DIV result read through the second source waits 36 cycles
        issue(5'd1, 5'd2, 5'd5, U_DIV, 0, "R3");
        issue(5'd0, 5'd5, 5'd14, U_ALU, 36, "R3");
        // R2: pending register on the bus with valid low
        issue(5'd1, 5'd2, 5'd6, U_MUL, 0, "R2");
        idle(2, 5'd6);

        // constrained random: small register range, held until issued (R3, R4)
        for (int i = 0; i < 800; i++) begin
            logic [1:0] u;
            int pick;
            pick = $urandom % 16;
            u = (pick == 0) ? U_DIV : (pick < 4) ? U_MULX : (pick < 9) ? U_MUL : U_ALU;
            if ($urandom % 6 == 0) idle(1, 5'($urandom % 8));
            else issue(5'($urandom % 8), 5'($urandom % 8), 5'($urandom % 8), u, -1, "R3");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule